// File: doc/BRIEF.md
# NAND Flash Page Controller

This block sits between a host and an 8-bit asynchronous NAND flash device. The host picks an operation with a 3-bit opcode and a 16-bit row address, then pulses a start input for one clock. The controller then runs the whole flash transaction: command latch cycles, address latch cycles, data transfer, the ready/busy wait and the status poll. At the end it raises a done level and three separate error flags.

A 2048-byte page buffer is built in. Before a program the host fills it through a byte-wide port. After a read, or a read of the ID, the host drains it through the same port. The controller owns the buffer while an operation runs. The host owns it when it holds the select input high and the controller is idle.

Each flash strobe is held low for `STROBE_CYC` clocks and then high for `STROBE_CYC` clocks. The default of 2 clocks gives 32 ns pulses at a 16 ns clock.

Top module: `nand_page_ctrl`

## Requirements
- R1: After reset the flash pins are idle and no result is reported: nf_ce_n=1, nf_we_n=1, nf_re_n=1, nf_cle=0, nf_ale=0, op_done=0, and all three error flags are 0.
- R2: Each operation sends its latch bytes in a fixed order. Command bytes go out with nf_cle=1 and address bytes with nf_ale=1.
  - Reset (opcode 011): FFh.
  - Read ID (101): 90h, then one address byte 00h.
  - Erase (100): 60h, row low byte, row high byte, D0h, 70h.
  - Program (001): 80h, 00h, 00h, row low, row high, then the data, then 10h and 70h.
  - Read (010): 00h, 00h, 00h, row low, row high, 30h.
- R3: A start pulse with opcode 000, 110 or 111 is ignored. No strobe toggles, nf_ce_n stays high, and op_done keeps its value.
- R4: A valid start clears op_done on the next clock. op_done then stays low until the operation ends. It then goes high and stays high until the next valid start.
- R5: Page program sends all 2048 buffer bytes to the flash in address order, one nf_we_n pulse each.
- R6: After a program, err_prog equals bit 0 of the status byte read back after command 70h.
- R7: After an erase, err_erase equals bit 0 of the status byte read back after command 70h.
- R8: Page read waits for nf_rdy high and then stores 2048 bytes from the flash into buffer addresses 0 to 2047 in order.
- R9: If nf_rdy stays low for TIMEOUT_CYC clocks after a confirm command, the operation ends. err_read is set for a page read, and no read strobes are issued.
- R10: Read ID stores 4 bytes from the flash into buffer addresses 0 to 3.
- R11: The controller drives nf_dq only during command, address and write-data cycles. It never drives the bus while nf_re_n is low.
- R12: nf_ce_n is low for the whole of an operation, covering every strobe, and high when the controller is idle.
- R13: The host port writes the buffer only when buf_sel=1 and the controller is idle. buf_rdata shows the byte at buf_addr one clock after the address is applied.
- R14: Every nf_we_n and nf_re_n low pulse lasts exactly STROBE_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 3 | Operation select, sampled with op_start |
| op_start | input | 1 | One-clock start pulse |
| row_addr | input | 16 | Flash page or block row |
| op_done | output | 1 | High once the last operation has finished |
| err_prog | output | 1 | Program failed, valid with op_done |
| err_erase | output | 1 | Erase failed, valid with op_done |
| err_read | output | 1 | Read timed out, valid with op_done |
| buf_sel | input | 1 | Host claims the page buffer |
| buf_addr | input | 11 | Host buffer byte address |
| buf_wdata | input | 8 | Host write byte |
| buf_we | input | 1 | Host write enable |
| buf_rdata | output | 8 | Host read byte, one clock latency |
| nf_dq | inout | 8 | Flash data bus |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_rdy | input | 1 | Flash ready, low while busy |

## Verification
The bench targets several mistakes that are easy to make.

- Latch order. An address sequence with swapped row bytes, or with one column byte too few, puts the wrong latch log in the flash model.
- Off-by-one data counts. A count one short in program or read leaves the last page byte unsent or unstored. A status byte sampled after nf_re_n has risen makes the error flags read as floating data.
- Busy wait. A timeout that is never enforced hangs the bench. A read that strobes after a timeout shows up in the model's read counter.
- Ignored inputs. A design that does not ignore unknown opcodes, or host writes with buf_sel low, changes the latch log or the buffer contents that the bench reads back.

// File: rtl/nand_pkg.sv
package nand_pkg;

    localparam int ROW_W    = 16;
    localparam int ID_BYTES = 4;

    localparam logic [2:0] OP_PROG  = 3'b001;
    localparam logic [2:0] OP_READ  = 3'b010;
    localparam logic [2:0] OP_RST   = 3'b011;
    localparam logic [2:0] OP_ERASE = 3'b100;
    localparam logic [2:0] OP_RDID  = 3'b101;

    localparam logic [7:0] FC_READ1  = 8'h00;
    localparam logic [7:0] FC_READ2  = 8'h30;
    localparam logic [7:0] FC_PROG1  = 8'h80;
    localparam logic [7:0] FC_PROG2  = 8'h10;
    localparam logic [7:0] FC_ERASE1 = 8'h60;
    localparam logic [7:0] FC_ERASE2 = 8'hD0;
    localparam logic [7:0] FC_STATUS = 8'h70;
    localparam logic [7:0] FC_RDID   = 8'h90;
    localparam logic [7:0] FC_RESET  = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_WDATA,
        ST_CMD2,
        ST_WAIT,
        ST_STCMD,
        ST_STRD,
        ST_RDATA
    } seq_state_e;

    function automatic logic op_valid(input logic [2:0] op);
        return (op == OP_PROG) || (op == OP_READ) || (op == OP_RST) ||
               (op == OP_ERASE) || (op == OP_RDID);
    endfunction

    function automatic logic [7:0] first_cmd(input logic [2:0] op);
        case (op)
            OP_PROG:  return FC_PROG1;
            OP_READ:  return FC_READ1;
            OP_ERASE: return FC_ERASE1;
            OP_RDID:  return FC_RDID;
            default:  return FC_RESET;
        endcase
    endfunction

    function automatic logic [7:0] confirm_cmd(input logic [2:0] op);
        case (op)
            OP_PROG:  return FC_PROG2;
            OP_ERASE: return FC_ERASE2;
            default:  return FC_READ2;
        endcase
    endfunction

    function automatic logic [2:0] addr_last(input logic [2:0] op);
        case (op)
            OP_ERASE: return 3'd1;
            OP_RDID:  return 3'd0;
            default:  return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_en,
    input  logic [AW-1:0] host_addr,
    input  logic          host_we,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [AW-1:0] eng_addr,
    input  logic          eng_we,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    eng_rdata
);

    logic [7:0] mem [DEPTH];
    logic [7:0] hrd_d, hrd_q;

    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_addr] <= eng_wdata;
        end else if (host_en && host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    always_comb begin
        hrd_d = hrd_q;
        if (host_en) begin
            hrd_d = mem[host_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hrd_q <= '0;
        end else begin
            hrd_q <= hrd_d;
        end
    end

    assign host_rdata = hrd_q;
    assign eng_rdata  = mem[eng_addr];

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int STROBE_CYC  = 2,
    parameter int TWB_CYC     = 4,
    parameter int TIMEOUT_CYC = 65535,
    localparam int COL_W      = $clog2(PAGE_BYTES),
    localparam int PH_W       = (STROBE_CYC > 1) ? $clog2(2 * STROBE_CYC) : 1,
    localparam int TMR_W      = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       cmd,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             rdy,
    input  logic [7:0]       dq_in,
    input  logic [7:0]       buf_rd,
    output logic             busy,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic             dq_oe,
    output logic [7:0]       dq_out,
    output logic [COL_W-1:0] buf_addr,
    output logic             buf_we,
    output logic [7:0]       buf_wd,
    output logic             done,
    output logic             err_prog,
    output logic             err_erase,
    output logic             err_read
);

    localparam logic [PH_W-1:0]  PH_LO_END = PH_W'(STROBE_CYC - 1);
    localparam logic [PH_W-1:0]  PH_END    = PH_W'(2 * STROBE_CYC - 1);
    localparam logic [COL_W-1:0] PAGE_END  = COL_W'(PAGE_BYTES - 1);
    localparam logic [COL_W-1:0] ID_END    = COL_W'(ID_BYTES - 1);
    localparam logic [TMR_W-1:0] TWB_T     = TMR_W'(TWB_CYC);
    localparam logic [TMR_W-1:0] TMO_T     = TMR_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [2:0]       op;
        logic [ROW_W-1:0] row;
        logic [PH_W-1:0]  ph;
        logic [COL_W-1:0] cnt;
        logic [TMR_W-1:0] tmr;
        logic             done;
        logic             ep;
        logic             ee;
        logic             er;
    } seq_t;

    seq_t s_d, s_q;

    logic wr_ph, rd_ph, lo, last, smp;
    logic [7:0] abyte;

    always_comb begin
        wr_ph = (s_q.st == ST_CMD1) || (s_q.st == ST_ADDR) || (s_q.st == ST_WDATA) ||
                (s_q.st == ST_CMD2) || (s_q.st == ST_STCMD);
        rd_ph = (s_q.st == ST_STRD) || (s_q.st == ST_RDATA);
        lo    = s_q.ph <= PH_LO_END;
        last  = s_q.ph == PH_END;
        smp   = rd_ph && (s_q.ph == PH_LO_END);
    end

    always_comb begin
        case (s_q.op)
            OP_ERASE: abyte = s_q.cnt[0] ? s_q.row[15:8] : s_q.row[7:0];
            OP_RDID:  abyte = 8'h00;
            default: begin
                if (s_q.cnt[1:0] == 2'd2)      abyte = s_q.row[7:0];
                else if (s_q.cnt[1:0] == 2'd3) abyte = s_q.row[15:8];
                else                           abyte = 8'h00;
            end
        endcase
    end

    always_comb begin
        case (s_q.st)
            ST_CMD1:  dq_out = first_cmd(s_q.op);
            ST_CMD2:  dq_out = confirm_cmd(s_q.op);
            ST_STCMD: dq_out = FC_STATUS;
            ST_ADDR:  dq_out = abyte;
            ST_WDATA: dq_out = buf_rd;
            default:  dq_out = 8'h00;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (wr_ph || rd_ph) begin
            s_d.ph = last ? '0 : s_q.ph + 1'b1;
        end
        case (s_q.st)
            ST_IDLE: begin
                if (start && op_valid(cmd)) begin
                    s_d.st   = ST_CMD1;
                    s_d.op   = cmd;
                    s_d.row  = row_addr;
                    s_d.ph   = '0;
                    s_d.cnt  = '0;
                    s_d.done = 1'b0;
                    s_d.ep   = 1'b0;
                    s_d.ee   = 1'b0;
                    s_d.er   = 1'b0;
                end
            end
            ST_CMD1: begin
                if (last) begin
                    s_d.cnt = '0;
                    s_d.tmr = '0;
                    s_d.st  = (s_q.op == OP_RST) ? ST_WAIT : ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (last) begin
                    if (s_q.cnt[2:0] == addr_last(s_q.op)) begin
                        s_d.cnt = '0;
                        case (s_q.op)
                            OP_RDID: s_d.st = ST_RDATA;
                            OP_PROG: s_d.st = ST_WDATA;
                            default: s_d.st = ST_CMD2;
                        endcase
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                if (last) begin
                    if (s_q.cnt == PAGE_END) begin
                        s_d.cnt = '0;
                        s_d.st  = ST_CMD2;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_CMD2: begin
                if (last) begin
                    s_d.tmr = '0;
                    s_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                s_d.tmr = s_q.tmr + 1'b1;
                if ((s_q.tmr >= TWB_T) && rdy) begin
                    s_d.ph  = '0;
                    s_d.cnt = '0;
                    case (s_q.op)
                        OP_READ: s_d.st = ST_RDATA;
                        OP_RST: begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end
                        default: s_d.st = ST_STCMD;
                    endcase
                end else if (s_q.tmr == TMO_T) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.er   = (s_q.op == OP_READ);
                end
            end
            ST_STCMD: begin
                if (last) s_d.st = ST_STRD;
            end
            ST_STRD: begin
                if (smp) begin
                    if (s_q.op == OP_PROG) s_d.ep = dq_in[0];
                    else                   s_d.ee = dq_in[0];
                end
                if (last) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            ST_RDATA: begin
                if (last) begin
                    if (s_q.cnt == ((s_q.op == OP_RDID) ? ID_END : PAGE_END)) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.st != ST_IDLE;
    assign cle       = (s_q.st == ST_CMD1) || (s_q.st == ST_CMD2) || (s_q.st == ST_STCMD);
    assign ale       = s_q.st == ST_ADDR;
    assign we_n      = !(wr_ph && lo);
    assign re_n      = !(rd_ph && lo);
    assign dq_oe     = wr_ph;
    assign buf_addr  = s_q.cnt;
    assign buf_we    = (s_q.st == ST_RDATA) && smp;
    assign buf_wd    = dq_in;
    assign done      = s_q.done;
    assign err_prog  = s_q.ep;
    assign err_erase = s_q.ee;
    assign err_read  = s_q.er;

endmodule

// File: rtl/nand_page_ctrl.sv
module nand_page_ctrl
    import nand_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int STROBE_CYC  = 2,
    parameter int TWB_CYC     = 4,
    parameter int TIMEOUT_CYC = 65535,
    localparam int COL_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_code,
    input  logic             op_start,
    input  logic [ROW_W-1:0] row_addr,
    output logic             op_done,
    output logic             err_prog,
    output logic             err_erase,
    output logic             err_read,
    input  logic             buf_sel,
    input  logic [COL_W-1:0] buf_addr,
    input  logic [7:0]       buf_wdata,
    input  logic             buf_we,
    output logic [7:0]       buf_rdata,
    inout  wire  [7:0]       nf_dq,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic             nf_ce_n,
    input  logic             nf_rdy
);

    logic             busy, drv_en, eng_we;
    logic [7:0]       drv_byte, eng_wd, eng_rd;
    logic [COL_W-1:0] eng_addr;

    nand_seq #(
        .PAGE_BYTES (PAGE_BYTES),
        .STROBE_CYC (STROBE_CYC),
        .TWB_CYC    (TWB_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (op_start),
        .cmd      (op_code),
        .row_addr (row_addr),
        .rdy      (nf_rdy),
        .dq_in    (nf_dq),
        .buf_rd   (eng_rd),
        .busy     (busy),
        .cle      (nf_cle),
        .ale      (nf_ale),
        .we_n     (nf_we_n),
        .re_n     (nf_re_n),
        .dq_oe    (drv_en),
        .dq_out   (drv_byte),
        .buf_addr (eng_addr),
        .buf_we   (eng_we),
        .buf_wd   (eng_wd),
        .done     (op_done),
        .err_prog (err_prog),
        .err_erase(err_erase),
        .err_read (err_read)
    );

    nand_page_buf #(
        .DEPTH(PAGE_BYTES)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .host_en   (buf_sel && !busy),
        .host_addr (buf_addr),
        .host_we   (buf_we),
        .host_wdata(buf_wdata),
        .host_rdata(buf_rdata),
        .eng_addr  (eng_addr),
        .eng_we    (eng_we),
        .eng_wdata (eng_wd),
        .eng_rdata (eng_rd)
    );

    assign nf_dq   = drv_en ? drv_byte : 8'hzz;
    assign nf_ce_n = !busy;

endmodule

// File: rtl/nand_page_ctrl_chk.sv
module nand_page_ctrl_chk
    import nand_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_code,
    input logic       op_start,
    input logic       op_done,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic       nf_ce_n,
    input logic       drv_en
);

    localparam int CW = $clog2(STROBE_CYC + 2) + 1;

    logic [CW-1:0] we_lo, re_lo;
    logic          we_prev, re_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo   <= '0;
            re_lo   <= '0;
            we_prev <= 1'b1;
            re_prev <= 1'b1;
        end else begin
            we_lo   <= nf_we_n ? '0 : we_lo + 1'b1;
            re_lo   <= nf_re_n ? '0 : re_lo + 1'b1;
            we_prev <= nf_we_n;
            re_prev <= nf_re_n;
        end
    end

    a_r14_we_width: assert property (@(posedge clk) disable iff (rst)
        (nf_we_n && !we_prev) |-> (we_lo == CW'(STROBE_CYC)));

    a_r14_re_width: assert property (@(posedge clk) disable iff (rst)
        (nf_re_n && !re_prev) |-> (re_lo == CW'(STROBE_CYC)));

    a_r11_release_on_read: assert property (@(posedge clk) disable iff (rst)
        !nf_re_n |-> !drv_en);

    a_r12_ce_covers_strobes: assert property (@(posedge clk) disable iff (rst)
        (!nf_we_n || !nf_re_n || nf_cle || nf_ale) |-> !nf_ce_n);

    a_r3_nop_ignored: assert property (@(posedge clk) disable iff (rst)
        (op_start && nf_ce_n && !op_valid(op_code)) |=> nf_ce_n);

    a_r4_done_clears: assert property (@(posedge clk) disable iff (rst)
        (op_start && nf_ce_n && op_valid(op_code)) |=> (!op_done && !nf_ce_n));

    a_r4_done_holds: assert property (@(posedge clk) disable iff (rst)
        (op_done && !op_start) |=> op_done);

endmodule

bind nand_page_ctrl nand_page_ctrl_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_code (op_code),
    .op_start(op_start),
    .op_done (op_done),
    .nf_cle  (nf_cle),
    .nf_ale  (nf_ale),
    .nf_we_n (nf_we_n),
    .nf_re_n (nf_re_n),
    .nf_ce_n (nf_ce_n),
    .drv_en  (drv_en)
);

// File: tb/nand_page_ctrl_test.sv
`timescale 1ns/1ps
module nand_page_ctrl_test;

    localparam int CLK_PERIOD = 16;
    localparam int PAGE       = 2048;
    localparam int STROBE     = 2;
    localparam int TMO        = 3000;
    localparam int BUSY_OK    = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_code = 3'b000;
    logic        op_start = 1'b0;
    logic [15:0] row_addr = '0;
    logic        op_done, err_prog, err_erase, err_read;
    logic        buf_sel = 1'b0;
    logic [10:0] buf_addr = '0;
    logic [7:0]  buf_wdata = '0;
    logic        buf_we = 1'b0;
    logic [7:0]  buf_rdata;
    wire  [7:0]  nf_dq;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_ce_n, nf_rdy;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = !clk;

    nand_page_ctrl #(
        .PAGE_BYTES (PAGE),
        .STROBE_CYC (STROBE),
        .TWB_CYC    (4),
        .TIMEOUT_CYC(TMO)
    ) uut (
        .clk(clk), .rst(rst), .op_code(op_code), .op_start(op_start),
        .row_addr(row_addr), .op_done(op_done), .err_prog(err_prog),
        .err_erase(err_erase), .err_read(err_read), .buf_sel(buf_sel),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we),
        .buf_rdata(buf_rdata), .nf_dq(nf_dq), .nf_cle(nf_cle),
        .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_ce_n(nf_ce_n), .nf_rdy(nf_rdy)
    );

    // ---------------- flash model ----------------
    logic [7:0] id_b [4] = '{8'hA7, 8'h3C, 8'h51, 8'hE2};
    logic [7:0] fpage [PAGE];
    logic [7:0] rdpage [PAGE];
    logic [8:0] lg [256];
    int   lg_n = 0, wptr = 0, wcnt = 0, rcnt = 0, rbase = 0;
    int   rmode = 0;
    longint cyc = 0, busy_until = 0;
    longint busy_len = BUSY_OK;
    logic stat_fail = 1'b0;
    logic [7:0] mout;
    int rptr;

    always @(posedge clk) cyc <= cyc + 1;
    assign nf_rdy = (cyc >= busy_until);

    always @(posedge nf_we_n) begin
        if (!nf_ce_n) begin
            if (nf_cle || nf_ale) begin
                lg[lg_n % 256] = {nf_cle, nf_dq};
                lg_n++;
            end
            if (nf_cle) begin
                rbase = rcnt;
                case (nf_dq)
                    8'h80: wptr = 0;
                    8'h10, 8'hD0, 8'h30, 8'hFF: busy_until = cyc + busy_len;
                    8'h70: rmode = 1;
                    8'h90: rmode = 2;
                    8'h00: rmode = 0;
                    default: ;
                endcase
            end else if (!nf_ale) begin
                fpage[wptr % PAGE] = nf_dq;
                wptr++;
                wcnt++;
            end
        end
    end

    always @(posedge nf_re_n) if (!nf_ce_n) rcnt++;

    always @* begin
        rptr = rcnt - rbase;
        if (rmode == 1)      mout = {7'b1100000, stat_fail};
        else if (rmode == 2) mout = id_b[rptr % 4];
        else                 mout = rdpage[rptr % PAGE];
    end

    assign nf_dq = (!nf_re_n && !nf_ce_n) ? mout : 8'hzz;

    // strobe width monitor
    int we_run = 0, re_run = 0, bad_w = 0, seen_w = 0;
    always @(negedge clk) begin
        if (!nf_we_n) we_run++;
        else begin
            if (we_run != 0) begin seen_w++; if (we_run != STROBE) bad_w++; end
            we_run = 0;
        end
        if (!nf_re_n) re_run++;
        else begin
            if (re_run != 0) begin seen_w++; if (re_run != STROBE) bad_w++; end
            re_run = 0;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<190000", wd);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    logic [8:0] ex [32];
    int ex_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic void exp_seq(input logic [2:0] op, input logic [15:0] row);
        ex_n = 0;
        case (op)
            3'b011: begin ex[0] = 9'h1FF; ex_n = 1; end
            3'b101: begin ex[0] = 9'h190; ex[1] = 9'h000; ex_n = 2; end
            3'b100: begin
                ex[0] = 9'h160; ex[1] = {1'b0, row[7:0]}; ex[2] = {1'b0, row[15:8]};
                ex[3] = 9'h1D0; ex[4] = 9'h170; ex_n = 5;
            end
            3'b001: begin
                ex[0] = 9'h180; ex[1] = 9'h000; ex[2] = 9'h000;
                ex[3] = {1'b0, row[7:0]}; ex[4] = {1'b0, row[15:8]};
                ex[5] = 9'h110; ex[6] = 9'h170; ex_n = 7;
            end
            default: begin
                ex[0] = 9'h100; ex[1] = 9'h000; ex[2] = 9'h000;
                ex[3] = {1'b0, row[7:0]}; ex[4] = {1'b0, row[15:8]};
                ex[5] = 9'h130; ex_n = 6;
            end
        endcase
    endfunction

    task automatic check_log(input int base, input string req);
        int bad = 0;
        if (lg_n - base != ex_n) bad = 1;
        else for (int i = 0; i < ex_n; i++) if (lg[(base + i) % 256] !== ex[i]) bad = i + 2;
        check(bad == 0, req, "latch sequence", lg_n - base, ex_n);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [15:0] row, input string req);
        int n = 0;
        @(negedge clk);
        op_code  = op;
        row_addr = row;
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        op_code  = 3'b000;
        check(!op_done && !nf_ce_n, "R4", "done low / CE low after start",
              {op_done, nf_ce_n}, 0);
        while (!op_done && n < 60000) begin @(negedge clk); n++; end
        check(op_done == 1'b1, req, "operation completes", op_done, 1);
        check(nf_ce_n == 1'b1, "R12", "CE high when idle", nf_ce_n, 1);
        repeat (5) @(negedge clk);
        check(op_done == 1'b1, "R4", "done held", op_done, 1);
    endtask

    task automatic host_write(input int a, input logic [7:0] d, input bit sel);
        buf_sel = sel; buf_addr = 11'(a); buf_wdata = d; buf_we = 1'b1;
        @(negedge clk);
        buf_we = 1'b0; buf_sel = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [7:0] d);
        buf_sel = 1'b1; buf_addr = 11'(a);
        @(negedge clk);
        d = buf_rdata;
        buf_sel = 1'b0;
    endtask

    logic [7:0] hpage [PAGE];

    task automatic fill_page();
        for (int i = 0; i < PAGE; i++) begin
            hpage[i] = 8'($urandom);
            host_write(i, hpage[i], 1'b1);
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int base, w0, r0, bad;
        logic [7:0] d;
        logic [15:0] row;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        check(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R1",
              "pins idle in reset", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 5'b11100);
        rst = 1'b0;
        @(negedge clk);
        check(!op_done && !err_prog && !err_erase && !err_read, "R1",
              "flags clear after reset", {op_done, err_prog, err_erase, err_read}, 0);

        // reset operation
        base = lg_n;
        run_op(3'b011, 16'h0000, "R2");
        exp_seq(3'b011, 16'h0000);
        check_log(base, "R2");

        // unknown opcodes are ignored
        foreach (ex[i]) ex[i] = '0;
        for (int k = 0; k < 3; k++) begin
            logic [2:0] nop;
            nop = (k == 0) ? 3'b000 : (k == 1) ? 3'b110 : 3'b111;
            base = lg_n;
            @(negedge clk);
            op_code = nop; op_start = 1'b1;
            @(negedge clk);
            op_start = 1'b0;
            repeat (10) begin
                check(nf_ce_n && nf_we_n && nf_re_n, "R3", "no activity on nop",
                      {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
                @(negedge clk);
            end
            check(op_done == 1'b1 && lg_n == base, "R3", "done kept, no latches",
                  lg_n - base, 0);
        end

        // read ID
        base = lg_n;
        run_op(3'b101, 16'h0000, "R10");
        exp_seq(3'b101, 16'h0000);
        check_log(base, "R2");
        for (int i = 0; i < 4; i++) begin
            host_read(i, d);
            check(d == id_b[i], "R10", "ID byte", d, id_b[i]);
        end

        // host port gating and latency
        host_write(5, 8'h5A, 1'b1);
        host_write(5, 8'hC3, 1'b0);
        host_read(5, d);
        check(d == 8'h5A, "R13", "write with select low ignored", d, 8'h5A);

        // program, passing status
        fill_page();
        row = 16'($urandom);
        stat_fail = 1'b0;
        base = lg_n; w0 = wcnt;
        run_op(3'b001, row, "R5");
        exp_seq(3'b001, row);
        check_log(base, "R2");
        check(wcnt - w0 == PAGE, "R5", "data byte count", wcnt - w0, PAGE);
        bad = 0;
        for (int i = 0; i < PAGE; i++) if (fpage[i] !== hpage[i]) bad++;
        check(bad == 0, "R5", "programmed data mismatches", bad, 0);
        check(err_prog == 1'b0, "R6", "err_prog on pass", err_prog, 0);

        // program, failing status
        fill_page();
        stat_fail = 1'b1;
        run_op(3'b001, 16'hFFFF, "R6");
        check(err_prog == 1'b1, "R6", "err_prog on fail", err_prog, 1);

        // erase fail then pass
        row = 16'($urandom);
        base = lg_n;
        run_op(3'b100, row, "R7");
        exp_seq(3'b100, row);
        check_log(base, "R2");
        check(err_erase == 1'b1 && err_prog == 1'b0, "R7", "err_erase on fail",
              {err_erase, err_prog}, 2'b10);
        stat_fail = 1'b0;
        run_op(3'b100, 16'h0040, "R7");
        check(err_erase == 1'b0, "R7", "err_erase on pass", err_erase, 0);

        // page read
        for (int i = 0; i < PAGE; i++) rdpage[i] = 8'($urandom);
        row = 16'($urandom);
        base = lg_n; r0 = rcnt;
        run_op(3'b010, row, "R8");
        exp_seq(3'b010, row);
        check_log(base, "R2");
        check(rcnt - r0 == PAGE && err_read == 1'b0, "R8", "read strobe count",
              rcnt - r0, PAGE);
        bad = 0;
        for (int i = 0; i < PAGE; i++) begin
            host_read(i, d);
            if (d !== rdpage[i]) bad++;
        end
        check(bad == 0, "R8", "buffer bytes wrong (bus released, R11)", bad, 0);

        // read timeout
        busy_len = 64'd1000000;
        r0 = rcnt;
        run_op(3'b010, 16'h1234, "R9");
        check(err_read == 1'b1, "R9", "err_read on timeout", err_read, 1);
        check(rcnt == r0, "R9", "no read strobes after timeout", rcnt - r0, 0);

        // recover the model with a reset operation
        busy_len = BUSY_OK;
        run_op(3'b011, 16'h0000, "R2");
        check(err_read == 1'b0, "R4", "flags cleared by new op", err_read, 0);

        check(bad_w == 0 && seen_w > 0, "R14", "strobe widths off", bad_w, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule